// File: doc/BRIEF.md
# Precise Exception Sequencer for a Five-Stage Pipeline

This block decides, cycle by cycle, whether the pipeline must abandon its normal flow because an instruction has faulted. Two fault sources are watched. The decode stage may report an opcode it does not recognise. The execute stage may report a signed arithmetic overflow. Each report arrives with the valid bit and the program counter of the instruction that carries it.

When a fault is taken, the block does four things in the same cycle. It zeroes the control of the stage registers that hold the faulting instruction and everything younger than it. It redirects fetch to the handler entry point. On the clock edge it stores the return address, which is the faulting PC plus four, and a one-bit cause code. Instructions older than the faulting one are not touched, so they still write back.

The handler entry point is either one fixed address or an address picked from a table indexed by cause. A parameter selects which of the two is used.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, `epc` is 0, `cause` is 0, and `redirect` and all three flush outputs are low.
- R2: In a cycle where `exValid` and `exOverflow` are both high, `flushIfId`, `flushIdEx`, `flushExMem` and `redirect` are all high. `flushExMem` blocks the faulting instruction's register write. After the edge, `cause` reads 1.
- R3: In a cycle where `idValid` and `idUndefOp` are high and no execute overflow is taken, `flushIfId`, `flushIdEx` and `redirect` are high and `flushExMem` is low, so the older instruction in execute retires. After the edge, `cause` reads 0.
- R4: On the edge that takes a fault, `epc` loads the faulting instruction's PC plus 4: `exPc`+4 for an overflow and `idPc`+4 for an undefined opcode.
- R5: When both faults are reported in the same cycle, the overflow is taken, because it belongs to the older instruction. The outputs then match R2, and `epc` loads `exPc`+4.
- R6: With `VECTORED`=0, `redirectPc` equals 0x8000_0180 whenever `redirect` is high.
- R7: With `VECTORED`=1, `redirectPc` equals 0xC000_0000 + 0x20 × cause. This gives 0xC000_0000 for an undefined opcode and 0xC000_0020 for an overflow.
- R8: A fault flag whose stage valid bit is low is ignored: there is no redirect, no flush, and `epc`/`cause` do not change.
- R9: In the cycle right after a taken fault, no new fault is accepted. `redirect` stays low and `epc`/`cause` keep the values just loaded, even if fault flags are still high.
- R10: In any cycle without a taken fault, `epc` and `cause` hold their values.
- R11: Consider the sequence sub/and/or at 0x40–0x48 followed by an overflowing add at 0x4C. The three older instructions write back, and the add's destination (and that of every younger instruction) is never written. The first fetch after the fault is at 0x8000_0180, with `epc`=0x50 and `cause`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idValid | input | 1 | Decode stage holds a real instruction |
| idUndefOp | input | 1 | Decode stage found an unknown opcode |
| idPc | input | XLEN | PC of the decode-stage instruction |
| exValid | input | 1 | Execute stage holds a real instruction |
| exOverflow | input | 1 | Execute stage produced a signed overflow |
| exPc | input | XLEN | PC of the execute-stage instruction |
| flushIfId | output | 1 | Zero the fetch/decode stage register |
| flushIdEx | output | 1 | Zero the decode/execute stage register |
| flushExMem | output | 1 | Zero the execute/memory stage register |
| redirect | output | 1 | Fetch from `redirectPc` next |
| redirectPc | output | XLEN | Handler entry address |
| epc | output | XLEN | Saved return address (faulting PC + 4) |
| cause | output | 1 | Saved cause: 0 undefined opcode, 1 overflow |

## Verification
Two of the block's functions can land in the same cycle: the undefined-opcode catch in decode and the overflow catch in execute. The bench creates this overlap by raising both flags in one cycle, giving the two instructions adjacent PCs. It then checks four things: the full three-register flush, the overflow handler address, `cause`=1, and an `epc` derived from the execute PC rather than the decode PC. A small pipeline model in the bench runs the faulting add together with its neighbours and confirms at writeback which instructions retire.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int CAUSE_W = 1;

  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = 1'b0;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF   = 1'b1;

  // Strobes sent from the fault selector to the state/datapath half
  typedef struct packed {
    logic               take;
    logic               selEx;
    logic [CAUSE_W-1:0] causeCode;
    logic               flushIfId;
    logic               flushIdEx;
    logic               flushExMem;
  } excStrobe_t;

endpackage

// File: rtl/exc_sel.sv
module exc_sel
  import exc_pkg::*;
(
  input  logic       idValid,
  input  logic       idUndefOp,
  input  logic       exValid,
  input  logic       exOverflow,
  input  logic       lockQ,
  output excStrobe_t strobe
);

  logic ovfHit;
  logic undHit;

  always_comb begin
    // The execute-stage instruction is older, so its fault wins
    ovfHit = exValid & exOverflow & ~lockQ;
    undHit = idValid & idUndefOp & ~lockQ;

    strobe.take       = ovfHit | undHit;
    strobe.selEx      = ovfHit;
    strobe.causeCode  = ovfHit ? CAUSE_OVF : CAUSE_UNDEF;
    // Every stage holding the faulting or a younger instruction is zeroed
    strobe.flushIfId  = ovfHit | undHit;
    strobe.flushIdEx  = ovfHit | undHit;
    strobe.flushExMem = ovfHit;
  end

endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter bit              VECTORED   = 1'b0,
  parameter logic [XLEN-1:0] FIXED_VEC  = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020
) (
  input  logic               clk,
  input  logic               rst_n,
  input  excStrobe_t         strobe,
  input  logic [XLEN-1:0]    idPc,
  input  logic [XLEN-1:0]    exPc,
  output logic [XLEN-1:0]    epc,
  output logic [CAUSE_W-1:0] cause,
  output logic               lockQ,
  output logic [XLEN-1:0]    handlerPc
);

  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic [XLEN-1:0] faultPc;

  assign faultPc = strobe.selEx ? exPc : idPc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
      lockQ <= 1'b0;
    end else begin
      lockQ <= strobe.take;
      if (strobe.take) begin
        epc   <= faultPc + PC_STEP;
        cause <= strobe.causeCode;
      end
    end
  end

  generate
    if (VECTORED) begin : g_vec
      assign handlerPc = VEC_BASE + (XLEN'(strobe.causeCode) * VEC_STRIDE);
    end else begin : g_fixed
      assign handlerPc = FIXED_VEC;
    end
  endgenerate

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter bit              VECTORED   = 1'b0,
  parameter logic [XLEN-1:0] FIXED_VEC  = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idValid,
  input  logic            idUndefOp,
  input  logic [XLEN-1:0] idPc,
  input  logic            exValid,
  input  logic            exOverflow,
  input  logic [XLEN-1:0] exPc,
  output logic            flushIfId,
  output logic            flushIdEx,
  output logic            flushExMem,
  output logic            redirect,
  output logic [XLEN-1:0] redirectPc,
  output logic [XLEN-1:0] epc,
  output logic            cause
);

  excStrobe_t strobe;
  logic       lockQ;

  exc_sel u_sel (
    .idValid   (idValid),
    .idUndefOp (idUndefOp),
    .exValid   (exValid),
    .exOverflow(exOverflow),
    .lockQ     (lockQ),
    .strobe    (strobe)
  );

  exc_state #(
    .XLEN      (XLEN),
    .VECTORED  (VECTORED),
    .FIXED_VEC (FIXED_VEC),
    .VEC_BASE  (VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .idPc     (idPc),
    .exPc     (exPc),
    .epc      (epc),
    .cause    (cause),
    .lockQ    (lockQ),
    .handlerPc(redirectPc)
  );

  assign flushIfId  = strobe.flushIfId;
  assign flushIdEx  = strobe.flushIdEx;
  assign flushExMem = strobe.flushExMem;
  assign redirect   = strobe.take;

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int              XLEN      = 32,
  parameter bit              VECTORED  = 1'b0,
  parameter logic [XLEN-1:0] FIXED_VEC = 32'h8000_0180
) (
  input logic            clk,
  input logic            rst_n,
  input logic            idValid,
  input logic            idUndefOp,
  input logic [XLEN-1:0] idPc,
  input logic            exValid,
  input logic            exOverflow,
  input logic [XLEN-1:0] exPc,
  input logic            flushIfId,
  input logic            flushIdEx,
  input logic            flushExMem,
  input logic            redirect,
  input logic [XLEN-1:0] redirectPc,
  input logic [XLEN-1:0] epc,
  input logic            cause,
  input logic            lockQ
);

  // R2
  ovf_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exValid && exOverflow && !lockQ) |-> (flushIfId && flushIdEx && flushExMem && redirect));

  // R3
  undef_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idValid && idUndefOp && !(exValid && exOverflow) && !lockQ) |-> (flushIdEx && flushIfId && !flushExMem));

  // R4
  epc_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && flushExMem) |=> (epc == $past(exPc) + 32'd4) && cause);

  // R4
  epc_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !flushExMem) |=> (epc == $past(idPc) + 32'd4) && !cause);

  // R6
  fixed_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (VECTORED || redirectPc == FIXED_VEC));

  // R8
  invalid_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idValid && !exValid) |-> (!redirect && !flushIfId && !flushIdEx && !flushExMem));

  // R9
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> ($stable(epc) && $stable(cause)));

endmodule

bind exc_ctrl exc_ctrl_chk #(
  .XLEN     (XLEN),
  .VECTORED (VECTORED),
  .FIXED_VEC(FIXED_VEC)
) u_chk (.*);

// File: tb/test_exc_ctrl.sv
`timescale 1ns/1ps
module test_exc_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idValid = 1'b0, idUndefOp = 1'b0;
  logic        exValid = 1'b0, exOverflow = 1'b0;
  logic [31:0] idPc = '0, exPc = '0;
  logic        flushIfId, flushIdEx, flushExMem, redirect, cause;
  logic [31:0] redirectPc, epc;
  logic        flushIfIdV, flushIdExV, flushExMemV, redirectV, causeV;
  logic [31:0] redirectPcV, epcV;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  exc_ctrl i_exc_ctrl (
    .clk(clk), .rst_n(rst_n),
    .idValid(idValid), .idUndefOp(idUndefOp), .idPc(idPc),
    .exValid(exValid), .exOverflow(exOverflow), .exPc(exPc),
    .flushIfId(flushIfId), .flushIdEx(flushIdEx), .flushExMem(flushExMem),
    .redirect(redirect), .redirectPc(redirectPc), .epc(epc), .cause(cause)
  );

  exc_ctrl #(.VECTORED(1'b1)) i_exc_ctrl_vec (
    .clk(clk), .rst_n(rst_n),
    .idValid(idValid), .idUndefOp(idUndefOp), .idPc(idPc),
    .exValid(exValid), .exOverflow(exOverflow), .exPc(exPc),
    .flushIfId(flushIfIdV), .flushIdEx(flushIdExV), .flushExMem(flushExMemV),
    .redirect(redirectV), .redirectPc(redirectPcV), .epc(epcV), .cause(causeV)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    idValid = 0; idUndefOp = 0; exValid = 0; exOverflow = 0;
    @(negedge clk);
  endtask

  task automatic tReset();
    #1;
    check("R1", "epc", epc, 32'h0);
    check("R1", "cause", {31'b0, cause}, 32'h0);
    check("R1", "redirect/flush", {28'b0, redirect, flushIfId, flushIdEx, flushExMem}, 32'h0);
  endtask

  task automatic tOverflow();
    @(negedge clk);
    exValid = 1; exOverflow = 1; exPc = 32'h100;
    #1;
    check("R2", "flushes+redirect", {28'b0, redirect, flushIfId, flushIdEx, flushExMem}, 32'hF);
    check("R6", "fixed target", redirectPc, 32'h8000_0180);
    check("R7", "vectored ovf target", redirectPcV, 32'hC000_0020);
    @(negedge clk);
    // flags still raised: R9 lockout cycle
    check("R4", "epc ovf", epc, 32'h104);
    check("R2", "cause ovf", {31'b0, cause}, 32'h1);
    check("R9", "no redirect in lockout", {31'b0, redirect}, 32'h0);
    @(negedge clk);
    #1;
    check("R9", "epc held after lockout edge", epc, 32'h104);
    idle();
  endtask

  task automatic tUndef();
    @(negedge clk);
    idValid = 1; idUndefOp = 1; idPc = 32'h200; exValid = 1; exOverflow = 0; exPc = 32'h1FC;
    #1;
    check("R3", "flushIfId/IdEx/redirect", {29'b0, redirect, flushIfId, flushIdEx}, 32'h7);
    check("R3", "flushExMem low", {31'b0, flushExMem}, 32'h0);
    check("R7", "vectored undef target", redirectPcV, 32'hC000_0000);
    @(negedge clk);
    check("R4", "epc undef", epc, 32'h204);
    check("R3", "cause undef", {31'b0, cause}, 32'h0);
    idle();
  endtask

  task automatic tBoth();
    @(negedge clk);
    idValid = 1; idUndefOp = 1; idPc = 32'h300;
    exValid = 1; exOverflow = 1; exPc = 32'h2FC;
    #1;
    check("R5", "flushExMem taken", {31'b0, flushExMem}, 32'h1);
    check("R5", "vectored picks ovf", redirectPcV, 32'hC000_0020);
    @(negedge clk);
    check("R5", "epc from ex", epc, 32'h300);
    check("R5", "cause ovf", {31'b0, cause}, 32'h1);
    idle();
  endtask

  task automatic tInvalid();
    @(negedge clk);
    idValid = 0; idUndefOp = 1; idPc = 32'h400;
    exValid = 0; exOverflow = 1; exPc = 32'h3FC;
    #1;
    check("R8", "no redirect/flush", {28'b0, redirect, flushIfId, flushIdEx, flushExMem}, 32'h0);
    @(negedge clk);
    check("R10", "epc held", epc, 32'h300);
    check("R10", "cause held", {31'b0, cause}, 32'h1);
    idle();
  endtask

  function automatic int destOf(input logic [31:0] pc);
    case (pc)
      32'h40: return 11;
      32'h44: return 12;
      32'h48: return 13;
      32'h4C: return 1;
      32'h50: return 15;
      32'h54: return 16;
      32'h8000_0180: return 25;
      32'h8000_0184: return 26;
      default: return 0;
    endcase
  endfunction

  task automatic tProgram();
    logic        sv [5];
    logic [31:0] spc [5];
    bit   [31:0] wr;
    logic [31:0] fpc, handlerFetch;
    logic        f1, f2, f3, rd;
    logic [31:0] rpc;
    wr = '0; fpc = 32'h40; handlerFetch = '0;
    for (int s = 0; s < 5; s++) begin sv[s] = 0; spc[s] = '0; end
    f1 = 0; f2 = 0; f3 = 0; rd = 0; rpc = '0;
    for (int cyc = 0; cyc < 16; cyc++) begin
      @(negedge clk);
      if (sv[4] && destOf(spc[4]) != 0) wr[destOf(spc[4])] = 1'b1;
      sv[4] = sv[3];        spc[4] = spc[3];
      sv[3] = sv[2] & ~f3;  spc[3] = spc[2];
      sv[2] = sv[1] & ~f2;  spc[2] = spc[1];
      sv[1] = sv[0] & ~f1;  spc[1] = spc[0];
      if (rd) begin fpc = rpc; handlerFetch = rpc; end
      sv[0] = 1; spc[0] = fpc; fpc = fpc + 32'd4;
      exValid = sv[2]; exPc = spc[2]; exOverflow = (spc[2] == 32'h4C);
      idValid = sv[1]; idPc = spc[1]; idUndefOp = 0;
      #1;
      f1 = flushIfId; f2 = flushIdEx; f3 = flushExMem; rd = redirect; rpc = redirectPc;
    end
    // R11: older instructions retire, faulting and younger ones never write
    check("R11", "sub retired", {31'b0, wr[11]}, 32'h1);
    check("R11", "and retired", {31'b0, wr[12]}, 32'h1);
    check("R11", "or retired", {31'b0, wr[13]}, 32'h1);
    check("R11", "add dest unchanged", {31'b0, wr[1]}, 32'h0);
    check("R11", "younger slt not written", {31'b0, wr[15]}, 32'h0);
    check("R11", "younger lw not written", {31'b0, wr[16]}, 32'h0);
    check("R11", "handler fetch", handlerFetch, 32'h8000_0180);
    check("R11", "handler instr retired", {31'b0, wr[25]}, 32'h1);
    check("R11", "epc", epc, 32'h50);
    check("R11", "cause", {31'b0, cause}, 32'h1);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tReset();
    tOverflow();
    tUndef();
    tBoth();
    tInvalid();
    tProgram();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

endmodule